// File: doc/BRIEF.md
# Downstream Secondary Bus Reset Sequencer

This block runs the downstream side of a switch through a secondary bus reset while the upstream port keeps working. Software sets a reset bit in the upstream bridge control register. The block then steps through a fixed sequence:

1. It asks every downstream port whose link was up to send training sets with the hot-reset bit.
2. It strobes a selective register clear.
3. It has the downstream-fed TLP queues emptied.
4. It holds the downstream port logic in a graceful reset until software clears the bit.

While the sequence runs, two kinds of access are filtered:

- Any transaction aimed below the bridge is classified as an unsupported request. Transactions for the upstream port itself, such as Type 0 configuration accesses, pass untouched.
- Management-bus accesses to downstream registers read as zero, and writes to them are blocked.

The sequence has six phases: idle, propagate, clear, flush, hold and resume. The propagate phase lasts `PROP_CYCLES` cycles. The flush phase ends only on an empty acknowledgment from the queue logic.

Top module: `sbr_ctrl`

## Requirements
- R1: In the first clock edge that samples `sbr_bit` high while idle, `link_up` is captured. From the next cycle on, `ts1_hot_req` equals that captured mask for exactly `PROP_CYCLES` cycles. Later changes on `link_up` do not alter it, and it is zero in every other phase.
- R2: In the cycle after propagation, `clr_field_en` is high for one cycle only. For each port p, bits [p*FW +: FW] are high except those set in `STICKY_MASK` or `RWL_MASK`. With the defaults, each port slice reads 16'hFC0F.
- R3: `q_flush` rises in the cycle after the clear strobe. It stays high until a clock edge samples `q_empty` high, and drops in the following cycle.
- R4: `port_rst` is high from the clear cycle through the end of the hold phase, and low otherwise.
- R5: The hold phase lasts as long as `sbr_bit` stays high. After an edge samples it low, one resume cycle follows with `port_rst` low and `ds_ready` high, and the block then returns to idle.
- R6: `txn_ur` is `txn_valid & txn_below` from the propagate phase through the hold phase, and zero otherwise. A transaction with `txn_below` low, meaning it targets the upstream port itself, is never marked.
- R7: From the propagate phase through the hold phase, an access with `mgmt_tgt_ds` high returns zero on `mgmt_rdata` and keeps `mgmt_wr_en` low. All other accesses pass `mgmt_rdata_in` through, and `mgmt_wr_en` follows `mgmt_wr`.
- R8: After reset the block is idle. `ds_ready` is high, and `ts1_hot_req`, `clr_field_en`, `q_flush`, `port_rst` and `txn_ur` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sbr_bit | input | 1 | Secondary bus reset bit from upstream bridge control |
| link_up | input | NPORT | Per-port downstream link-up flags |
| ts1_hot_req | output | NPORT | Per-port request to send training sets with hot reset |
| clr_field_en | output | NPORT*FW | Per-port, per-field register clear strobe |
| q_flush | output | 1 | Discard queued downstream TLPs |
| q_empty | input | 1 | Queue logic reports all downstream TLPs discarded |
| port_rst | output | 1 | Graceful reset to downstream port logic |
| ds_ready | output | 1 | Downstream ports in normal operation |
| txn_valid | input | 1 | Upstream-side transaction present |
| txn_below | input | 1 | Transaction targets the secondary side of the bridge |
| txn_ur | output | 1 | Transaction classified as unsupported request |
| mgmt_wr | input | 1 | Management-bus write request |
| mgmt_tgt_ds | input | 1 | Management access targets a downstream-reset register |
| mgmt_rdata_in | input | DW | Read data from register storage |
| mgmt_rdata | output | DW | Read data returned to management bus |
| mgmt_wr_en | output | 1 | Write enable forwarded to register storage |

## Verification
The phase outputs change one cycle after the edge that samples their cause, because they decode a single state register. The propagate mask is seen at the first falling edge after `sbr_bit` is sampled, and the clear strobe follows exactly `PROP_CYCLES` cycles later. The flush and hold exits each appear one cycle after `q_empty` or the low `sbr_bit` is sampled. The filtering outputs `txn_ur`, `mgmt_rdata` and `mgmt_wr_en` are combinational and are checked in the same cycle as their inputs. The bench drives and samples only on falling edges and counts phase cycles from the known entry edge. Each check falls at the cycle the model predicts.

// File: rtl/sbr_ctrl.sv
module sbr_ctrl #(
  parameter int NPORT = 3,
  parameter int FW = 16,
  parameter int DW = 32,
  parameter int PROP_CYCLES = 8,
  parameter logic [FW-1:0] STICKY_MASK = 16'h00F0,
  parameter logic [FW-1:0] RWL_MASK = 16'h0300
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sbr_bit,
  input  logic [NPORT-1:0]    link_up,
  output logic [NPORT-1:0]    ts1_hot_req,
  output logic [NPORT*FW-1:0] clr_field_en,
  output logic                q_flush,
  input  logic                q_empty,
  output logic                port_rst,
  output logic                ds_ready,
  input  logic                txn_valid,
  input  logic                txn_below,
  output logic                txn_ur,
  input  logic                mgmt_wr,
  input  logic                mgmt_tgt_ds,
  input  logic [DW-1:0]       mgmt_rdata_in,
  output logic [DW-1:0]       mgmt_rdata,
  output logic                mgmt_wr_en
);

  localparam int CW = $clog2(PROP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(PROP_CYCLES - 1);
  localparam logic [FW-1:0] CLR_FIELDS = ~(STICKY_MASK | RWL_MASK);

  typedef enum logic [2:0] {S_IDLE, S_PROP, S_CLEAR, S_FLUSH, S_HOLD, S_RESUME} st_t;

  st_t             state;
  logic [CW-1:0]   cnt;
  logic [NPORT-1:0] mask;
  logic            busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      mask  <= '0;
    end else begin
      case (state)
        S_IDLE:   if (sbr_bit) begin
                    state <= S_PROP;
                    mask  <= link_up;
                    cnt   <= '0;
                  end
        S_PROP:   if (cnt == LAST) state <= S_CLEAR;
                  else cnt <= cnt + 1'b1;
        S_CLEAR:  state <= S_FLUSH;
        S_FLUSH:  if (q_empty) state <= S_HOLD;
        S_HOLD:   if (!sbr_bit) state <= S_RESUME;
        default:  state <= S_IDLE;
      endcase
    end
  end

  assign busy        = (state == S_PROP) || port_rst;
  assign ts1_hot_req = (state == S_PROP) ? mask : '0;
  assign q_flush     = (state == S_FLUSH);
  assign port_rst    = (state == S_CLEAR) || (state == S_FLUSH) || (state == S_HOLD);
  assign ds_ready    = !busy;
  assign txn_ur      = busy && txn_valid && txn_below;
  assign mgmt_rdata  = (busy && mgmt_tgt_ds) ? '0 : mgmt_rdata_in;
  assign mgmt_wr_en  = mgmt_wr && !(busy && mgmt_tgt_ds);

  for (genvar p = 0; p < NPORT; p++) begin : g_clr
    assign clr_field_en[p*FW +: FW] = (state == S_CLEAR) ? CLR_FIELDS : '0;
  end

  // R1
  ts1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ts1_hot_req) |-> !port_rst && !q_flush);

  // R2
  clr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_field_en) |=> !(|clr_field_en) && q_flush);

  // R3
  flush_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_flush && !q_empty) |=> q_flush);

  // R5
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rst && sbr_bit) |=> port_rst);

  // R6
  ur_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_ur |-> (txn_valid && txn_below && !ds_ready));

  // R7
  mgmt_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_rst && mgmt_tgt_ds) |-> (mgmt_rdata == '0) && !mgmt_wr_en);

endmodule

// File: tb/sbr_ctrl_bench.sv
module sbr_ctrl_bench;
  localparam int NPORT = 3, FW = 16, DW = 32, P = 8;
  localparam logic [FW-1:0] STK = 16'h00F0, RWL = 16'h0300;

  logic clk = 0, rst_n = 0;
  logic sbr_bit = 0, q_empty = 0, txn_valid = 0, txn_below = 0, mgmt_wr = 0, mgmt_tgt_ds = 0;
  logic [NPORT-1:0] link_up = '0;
  logic [DW-1:0] mgmt_rdata_in = '0;
  logic [NPORT-1:0] ts1_hot_req;
  logic [NPORT*FW-1:0] clr_field_en;
  logic q_flush, port_rst, ds_ready, txn_ur, mgmt_wr_en;
  logic [DW-1:0] mgmt_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sbr_ctrl u_sbr_ctrl (.*);

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NPORT*FW-1:0] exp_clr();
    logic [NPORT*FW-1:0] v = '0;
    for (int p = 0; p < NPORT; p++)
      for (int b = 0; b < FW; b++)
        v[p*FW+b] = !(STK[b] || RWL[b]);
    return v;
  endfunction

  function automatic logic exp_ur(bit in_rst, logic v, logic b);
    return in_rst && v && b;
  endfunction

  function automatic logic [DW-1:0] exp_rd(bit in_rst, logic tgt, logic [DW-1:0] d);
    return (in_rst && tgt) ? '0 : d;
  endfunction

  task automatic filt(bit in_rst, string ph);
    txn_valid = 1'($urandom); txn_below = 1'($urandom);
    mgmt_wr = 1'($urandom); mgmt_tgt_ds = 1'($urandom); mgmt_rdata_in = $urandom;
    #1;
    chk({"R6 ur ", ph}, txn_ur, exp_ur(in_rst, txn_valid, txn_below));
    chk({"R7 rdata ", ph}, mgmt_rdata, exp_rd(in_rst, mgmt_tgt_ds, mgmt_rdata_in));
    chk({"R7 wr ", ph}, mgmt_wr_en, mgmt_wr && !(in_rst && mgmt_tgt_ds));
  endtask

  task automatic episode(logic [NPORT-1:0] lk, int fdly, int hdly);
    @(negedge clk);
    link_up = lk; sbr_bit = 1;
    @(negedge clk);
    for (int i = 0; i < P; i++) begin
      chk("R1 ts1 mask", ts1_hot_req, lk);
      chk("R4 no rst in propagate", port_rst, 0);
      link_up = NPORT'($urandom);
      filt(1, "prop");
      @(negedge clk);
    end
    chk("R2 clear strobe", clr_field_en, exp_clr());
    chk("R1 ts1 off", ts1_hot_req, 0);
    chk("R4 rst in clear", port_rst, 1);
    @(negedge clk);
    chk("R2 strobe one cycle", clr_field_en, 0);
    for (int i = 0; i < fdly; i++) begin
      chk("R3 flush waiting", q_flush, 1);
      @(negedge clk);
    end
    chk("R3 flush before ack", q_flush, 1);
    q_empty = 1;
    @(negedge clk);
    q_empty = 0;
    chk("R3 flush dropped", q_flush, 0);
    for (int i = 0; i < hdly; i++) begin
      chk("R5 hold", port_rst, 1);
      filt(1, "hold");
      @(negedge clk);
    end
    sbr_bit = 0;
    @(negedge clk);
    chk("R5 resume rst", port_rst, 0);
    chk("R5 resume ready", ds_ready, 1);
    filt(0, "resume");
    @(negedge clk);
    chk("R8 idle ready", ds_ready, 1);
    chk("R1 ts1 idle", ts1_hot_req, 0);
    filt(0, "idle");
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R8 reset ready", ds_ready, 1);
    chk("R8 reset ts1", ts1_hot_req, 0);
    chk("R8 reset clr", clr_field_en, 0);
    chk("R8 reset flush", q_flush, 0);
    chk("R8 reset port_rst", port_rst, 0);
    rst_n = 1;
    @(negedge clk);
    filt(0, "idle");
    link_up = '1;
    @(negedge clk);
    chk("R1 no trigger", ts1_hot_req, 0);
    episode('0, 0, 1);
    episode('1, 3, 2);
    for (int e = 0; e < 6; e++)
      episode(NPORT'($urandom), $urandom_range(0, 5), $urandom_range(1, 6));
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule